// File: doc/BRIEF.md
# Adaptive Dead-Time Half-Bridge Gate Controller

This block turns a single PWM command into two gate-enable outputs, one for the high-side switch and one for the low-side switch of a synchronous buck bridge. It never enables both switches together. The dead time between them is not a fixed count. Before one gate is enabled, the block waits for feedback showing that the opposite gate has actually discharged below its turn-on threshold. It then waits a further short delay, set by a parameter.

The PWM pin is seen through two threshold comparators. Their outputs classify the pin as high, low or sitting in a mid-level window. When the pin stays in the window, the block turns off whichever switch was conducting. If the pin is still in the window after a hold-off time, both gates stay off and a shutdown flag is raised. An enable input and a supply-good flag gate both outputs off at once. Every wait for gate feedback is bounded by a timeout, and a timeout leaves both gates off with a fault flag set.

All comparator, feedback, enable and supply-good inputs pass through synchronizers of SYNC_STAGES flops before the state machine acts on them. All delays are counted in clock cycles.

Top module: `hb_deadtime_ctrl`

## Requirements
- R1: When the PWM level goes high, the low-side enable drops first. The high-side enable rises only after the synchronized low-side feedback has read "below threshold" for DLY_CYC+1 consecutive cycles. If that feedback is driven high before a clock edge, and the delay is not disturbed, the high-side enable is first seen after SYNC_STAGES+DLY_CYC+2 rising edges, counting from the edge just before the feedback changed. If the feedback drops during the delay, the wait restarts.
- R2: When the PWM level goes low, the high-side enable drops first. The low-side enable rises only after the high-side feedback reads "below threshold", following the same delay and latency rule as R1.
- R3: ug_en_o and lg_en_o are never both 1.
- R4: The PWM level is classified as follows: pwm_hi_i=1 and pwm_lo_i=0 is high; pwm_lo_i=1 and pwm_hi_i=0 is low; both 0 is the mid window. Both 1 is also treated as the mid window.
- R5: One cycle after the synchronized level reads mid, neither gate enable is asserted.
- R6: If the level stays mid, tri_off_o rises and both gates stay off. When mid is driven before an edge, tri_off_o is first seen after SYNC_STAGES+HOLD_CYC+2 rising edges. A stay in the window shorter than the hold-off never raises tri_off_o.
- R7: Shutdown ends as soon as the level leaves the window. A move to high then follows R1, and a move to low follows R2.
- R8: While en_i=0 or pgood_i=0, both gate enables are 0 in the same cycle, regardless of the PWM level.
- R9: A slow PWM move from low through the window to high only adds off time. It never produces an overlap.
- R10: After reset, or after enable or supply-good returns, both gates stay off until the synchronized level reads high or low. A mid level in this condition does not raise tri_off_o.
- R11: If the awaited feedback does not read "below threshold" within TMO_CYC+1 cycles, the opposite gate is not enabled and fault_o is raised with both gates off. fault_o clears on the next change of the PWM level, and the matching sequence then starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Driver enable |
| pgood_i | input | 1 | Supply above power-on reset level |
| pwm_hi_i | input | 1 | PWM pin above rising threshold |
| pwm_lo_i | input | 1 | PWM pin below falling threshold |
| lg_low_i | input | 1 | Low-side gate below turn-on threshold |
| ug_low_i | input | 1 | High-side gate-to-switch-node voltage below threshold |
| ug_en_o | output | 1 | High-side gate enable |
| lg_en_o | output | 1 | Low-side gate enable |
| tri_off_o | output | 1 | Mid-window shutdown active |
| fault_o | output | 1 | Gate feedback timeout |

## Verification
The assertions check on every cycle that the two enables never overlap, and that a gate enable only rises while the opposite feedback reads discharged. They also check that a mid level removes both enables on the next cycle, and that disable or supply loss clears both outputs. In addition, they check that the shutdown and fault flags only appear with both gates off and from the proper prior condition. The bench scenarios cover what the assertions cannot: the exact dead-time and hold-off latencies, and that a short window glitch raises no shutdown flag. They also cover fault entry when the feedback is stuck and its clearing on the next PWM change, the idle wait at a mid level after enable, and the full order of output events across slow transitions.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [1:0] {
    LVL_LOW,
    LVL_HIGH,
    LVL_MID
  } pwm_lvl_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_WAIT_LG,
    S_DLY_UG,
    S_UG_ON,
    S_WAIT_UG,
    S_DLY_LG,
    S_LG_ON,
    S_TRI_WAIT,
    S_TRI,
    S_FAULT
  } hb_state_e;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '0;
    end else begin
      pipe_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/hb_pwm_classify.sv
module hb_pwm_classify
  import hb_pkg::*;
(
  input  logic     hi_i,
  input  logic     lo_i,
  output pwm_lvl_e lvl_o
);
  // both comparators set is impossible on a sane pin; treat as window
  always_comb begin
    unique case ({hi_i, lo_i})
      2'b10:   lvl_o = LVL_HIGH;
      2'b01:   lvl_o = LVL_LOW;
      default: lvl_o = LVL_MID;
    endcase
  end
endmodule

// File: rtl/hb_down_timer.sv
module hb_down_timer #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/hb_deadtime_ctrl.sv
module hb_deadtime_ctrl
  import hb_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DLY_CYC     = 2,
  parameter int HOLD_CYC    = 2,
  parameter int TMO_CYC     = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic pgood_i,
  input  logic pwm_hi_i,
  input  logic pwm_lo_i,
  input  logic lg_low_i,
  input  logic ug_low_i,
  output logic ug_en_o,
  output logic lg_en_o,
  output logic tri_off_o,
  output logic fault_o
);
  localparam int MAX_A = (DLY_CYC > HOLD_CYC) ? DLY_CYC : HOLD_CYC;
  localparam int MAX_C = (TMO_CYC > MAX_A) ? TMO_CYC : MAX_A;
  localparam int CNT_W = $clog2(MAX_C + 1);
  localparam int NSYNC = 6;

  logic [NSYNC-1:0] raw_in, syn_in;
  logic hi_s, lo_s, lg_low_s, ug_low_s, en_s, pg_s, en_ok;

  assign raw_in = {pwm_hi_i, pwm_lo_i, lg_low_i, ug_low_i, en_i, pgood_i};

  hb_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_in),
    .q_o   (syn_in)
  );

  assign {hi_s, lo_s, lg_low_s, ug_low_s, en_s, pg_s} = syn_in;
  assign en_ok = en_s & pg_s;

  pwm_lvl_e lvl;
  hb_pwm_classify u_cls (
    .hi_i (hi_s),
    .lo_i (lo_s),
    .lvl_o(lvl)
  );

  hb_state_e state_q, state_d;
  pwm_lvl_e  fault_lvl_q;
  logic      tmr_load, tmr_done;
  logic [CNT_W-1:0] tmr_val;

  hb_down_timer #(.W(CNT_W)) u_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(tmr_load),
    .val_i (tmr_val),
    .done_o(tmr_done)
  );

  always_comb begin
    state_d = state_q;
    if (!en_ok) begin
      state_d = S_IDLE;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (lvl == LVL_HIGH)     state_d = S_WAIT_LG;
          else if (lvl == LVL_LOW) state_d = S_WAIT_UG;
        end
        S_WAIT_LG: begin
          if (lvl == LVL_MID)      state_d = S_TRI_WAIT;
          else if (lvl == LVL_LOW) state_d = S_WAIT_UG;
          else if (lg_low_s)       state_d = S_DLY_UG;
          else if (tmr_done)       state_d = S_FAULT;
        end
        S_DLY_UG: begin
          if (lvl == LVL_MID)      state_d = S_TRI_WAIT;
          else if (lvl == LVL_LOW) state_d = S_WAIT_UG;
          else if (!lg_low_s)      state_d = S_WAIT_LG;
          else if (tmr_done)       state_d = S_UG_ON;
        end
        S_UG_ON: begin
          if (lvl == LVL_MID)      state_d = S_TRI_WAIT;
          else if (lvl == LVL_LOW) state_d = S_WAIT_UG;
        end
        S_WAIT_UG: begin
          if (lvl == LVL_MID)       state_d = S_TRI_WAIT;
          else if (lvl == LVL_HIGH) state_d = S_WAIT_LG;
          else if (ug_low_s)        state_d = S_DLY_LG;
          else if (tmr_done)        state_d = S_FAULT;
        end
        S_DLY_LG: begin
          if (lvl == LVL_MID)       state_d = S_TRI_WAIT;
          else if (lvl == LVL_HIGH) state_d = S_WAIT_LG;
          else if (!ug_low_s)       state_d = S_WAIT_UG;
          else if (tmr_done)        state_d = S_LG_ON;
        end
        S_LG_ON: begin
          if (lvl == LVL_MID)       state_d = S_TRI_WAIT;
          else if (lvl == LVL_HIGH) state_d = S_WAIT_LG;
        end
        S_TRI_WAIT: begin
          if (lvl == LVL_HIGH)     state_d = S_WAIT_LG;
          else if (lvl == LVL_LOW) state_d = S_WAIT_UG;
          else if (tmr_done)       state_d = S_TRI;
        end
        S_TRI: begin
          if (lvl == LVL_HIGH)     state_d = S_WAIT_LG;
          else if (lvl == LVL_LOW) state_d = S_WAIT_UG;
        end
        S_FAULT: begin
          // held until the PWM level changes
          if (lvl != fault_lvl_q) begin
            unique case (lvl)
              LVL_HIGH: state_d = S_WAIT_LG;
              LVL_LOW:  state_d = S_WAIT_UG;
              default:  state_d = S_TRI_WAIT;
            endcase
          end
        end
        default: state_d = S_IDLE;
      endcase
    end
  end

  assign tmr_load = (state_d != state_q);

  always_comb begin
    unique case (state_d)
      S_WAIT_LG, S_WAIT_UG: tmr_val = CNT_W'(TMO_CYC);
      S_DLY_UG, S_DLY_LG:   tmr_val = CNT_W'(DLY_CYC);
      S_TRI_WAIT:           tmr_val = CNT_W'(HOLD_CYC);
      default:              tmr_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      fault_lvl_q <= LVL_MID;
    end else begin
      state_q <= state_d;
      if (state_d == S_FAULT && state_q != S_FAULT) fault_lvl_q <= lvl;
    end
  end

  logic ug_on, lg_on;
  assign ug_on = (state_q == S_UG_ON);
  assign lg_on = (state_q == S_LG_ON);

  // raw gating so disable acts without synchronizer latency
  assign ug_en_o   = ug_on & en_i & pgood_i;
  assign lg_en_o   = lg_on & en_i & pgood_i;
  assign tri_off_o = (state_q == S_TRI);
  assign fault_o   = (state_q == S_FAULT);

  p_no_overlap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ug_en_o && lg_en_o))
    else $error("R3 overlap");

  p_ug_rise_fb_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ug_on) |-> $past(lg_low_s))
    else $error("R1 high side rose without low-side feedback");

  p_lg_rise_fb_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lg_on) |-> $past(ug_low_s))
    else $error("R2 low side rose without high-side feedback");

  p_mid_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl == LVL_MID) |=> (!ug_on && !lg_on))
    else $error("R5 gate on after mid level");

  p_tri_from_mid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tri_off_o) |-> $past(lvl == LVL_MID))
    else $error("R6 shutdown flag without mid level");

  p_tri_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tri_off_o |-> (!ug_en_o && !lg_en_o))
    else $error("R6 gate on in shutdown");

  p_force_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && pgood_i) |-> (!ug_en_o && !lg_en_o))
    else $error("R8 gate on while disabled");

  p_idle_mid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && lvl == LVL_MID) |=> !tri_off_o)
    else $error("R10 shutdown flag from idle");

  p_fault_src_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_o) |-> $past(state_q == S_WAIT_LG || state_q == S_WAIT_UG))
    else $error("R11 fault not from feedback wait");

  p_fault_off_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (!ug_en_o && !lg_en_o))
    else $error("R11 gate on in fault");
endmodule

// File: tb/tb_hb_deadtime_ctrl.sv
module tb_hb_deadtime_ctrl;
  localparam int SYNC_STAGES = 2;
  localparam int DLY_CYC     = 2;
  localparam int HOLD_CYC    = 2;
  localparam int TMO_CYC     = 16;
  localparam int GATE_LAT    = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0, pgood_i = 1'b0;
  logic pwm_hi_i = 1'b0, pwm_lo_i = 1'b1;
  logic lg_low_i = 1'b1, ug_low_i = 1'b1;
  logic ug_en_o, lg_en_o, tri_off_o, fault_o;

  always #5 clk = ~clk;

  hb_deadtime_ctrl #(
    .SYNC_STAGES(SYNC_STAGES), .DLY_CYC(DLY_CYC),
    .HOLD_CYC(HOLD_CYC), .TMO_CYC(TMO_CYC)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .pgood_i(pgood_i),
    .pwm_hi_i(pwm_hi_i), .pwm_lo_i(pwm_lo_i),
    .lg_low_i(lg_low_i), .ug_low_i(ug_low_i),
    .ug_en_o(ug_en_o), .lg_en_o(lg_en_o),
    .tri_off_o(tri_off_o), .fault_o(fault_o)
  );

  typedef struct {
    logic [3:0] v;
    string      req;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0, fails = 0;
  int cyc = 0;
  int overlap_seen = 0, tri_rises = 0;
  int t_lg_fb = 0, t_ug_fb = 0, t_ug_rise = 0, t_lg_rise = 0, t_tri_rise = 0;
  logic stick_lg = 1'b0;
  logic [GATE_LAT-1:0] lg_hist = '0, ug_hist = '0;
  logic [3:0] prev_v = 4'b0000;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [3:0] v, input string req);
    exp_t e;
    e.v = v;
    e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pwm(input logic hi, input logic lo);
    pwm_hi_i = hi;
    pwm_lo_i = lo;
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // gate model: feedback follows the enable after GATE_LAT cycles
  always @(negedge clk) begin
    logic nl, nu;
    lg_hist = {lg_hist[GATE_LAT-2:0], lg_en_o};
    ug_hist = {ug_hist[GATE_LAT-2:0], ug_en_o};
    nl = stick_lg ? 1'b0 : ~lg_hist[GATE_LAT-1];
    nu = ~ug_hist[GATE_LAT-1];
    if (nl && !lg_low_i) t_lg_fb = cyc;
    if (nu && !ug_low_i) t_ug_fb = cyc;
    lg_low_i = nl;
    ug_low_i = nu;
  end

  // monitor: pop expected output vector {ug,lg,tri,fault} on every change
  always @(negedge clk) begin
    logic [3:0] v;
    if (rst_ni) begin
      v = {ug_en_o, lg_en_o, tri_off_o, fault_o};
      if (ug_en_o && lg_en_o) overlap_seen++;
      if (v != prev_v) begin
        if (v[3] && !prev_v[3]) t_ug_rise = cyc;
        if (v[2] && !prev_v[2]) t_lg_rise = cyc;
        if (v[1] && !prev_v[1]) begin
          t_tri_rise = cyc;
          tri_rises++;
        end
        if (exp_q.size() == 0) begin
          chk(1'b0, "unexpected_event", int'(v), -1);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(v == e.v, e.req, int'(v), int'(e.v));
        end
        prev_v = v;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int t0;
    wait_cyc(3);
    rst_ni = 1'b1;
    wait_cyc(2);
    chk({ug_en_o, lg_en_o, tri_off_o, fault_o} == 4'b0000, "R10_reset",
        int'({ug_en_o, lg_en_o, tri_off_o, fault_o}), 0);

    // R8: disabled or no supply, PWM high
    set_pwm(1, 0);
    pgood_i = 1'b1;
    wait_cyc(20);
    chk(!ug_en_o && !lg_en_o, "R8_en_low", int'({ug_en_o, lg_en_o}), 0);
    en_i = 1'b1;
    pgood_i = 1'b0;
    wait_cyc(20);
    chk(!ug_en_o && !lg_en_o, "R8_pgood_low", int'({ug_en_o, lg_en_o}), 0);

    // R10: enabled at mid level stays idle without shutdown flag
    set_pwm(0, 0);
    pgood_i = 1'b1;
    wait_cyc(20);
    chk({ug_en_o, lg_en_o, tri_off_o} == 3'b000, "R10_mid_idle",
        int'({ug_en_o, lg_en_o, tri_off_o}), 0);

    // R2: go low from idle
    push(4'b0100, "R2");
    set_pwm(0, 1);
    wait_cyc(20);
    chk(lg_en_o, "R2_lg_on", int'(lg_en_o), 1);

    // R1: rising sequence and dead-time latency
    push(4'b0000, "R1");
    push(4'b1000, "R1");
    set_pwm(1, 0);
    wait_cyc(25);
    chk(ug_en_o, "R1_ug_on", int'(ug_en_o), 1);
    chk(t_ug_rise - t_lg_fb == SYNC_STAGES + DLY_CYC + 2, "R1_latency",
        t_ug_rise - t_lg_fb, SYNC_STAGES + DLY_CYC + 2);

    // R2: falling sequence and latency
    push(4'b0000, "R2");
    push(4'b0100, "R2");
    set_pwm(0, 1);
    wait_cyc(25);
    chk(lg_en_o, "R2_lg_on2", int'(lg_en_o), 1);
    chk(t_lg_rise - t_ug_fb == SYNC_STAGES + DLY_CYC + 2, "R2_latency",
        t_lg_rise - t_ug_fb, SYNC_STAGES + DLY_CYC + 2);

    // R11: low-side feedback stuck, timeout fault
    stick_lg = 1'b1;
    push(4'b0000, "R1");
    push(4'b0001, "R11");
    set_pwm(1, 0);
    wait_cyc(40);
    chk(fault_o && !ug_en_o, "R11_fault", int'({fault_o, ug_en_o}), 2);
    stick_lg = 1'b0;
    wait_cyc(10);
    chk(fault_o && !ug_en_o, "R11_fault_held", int'({fault_o, ug_en_o}), 2);
    push(4'b0000, "R11");
    push(4'b0100, "R11");
    set_pwm(0, 1);
    wait_cyc(25);
    chk(!fault_o && lg_en_o, "R11_clear", int'({fault_o, lg_en_o}), 1);

    // back to high side
    push(4'b0000, "R1");
    push(4'b1000, "R1");
    set_pwm(1, 0);
    wait_cyc(25);

    // R6: short window glitch raises no flag
    t0 = tri_rises;
    push(4'b0000, "R5");
    push(4'b1000, "R7");
    set_pwm(0, 0);
    wait_cyc(1);
    set_pwm(1, 0);
    wait_cyc(25);
    chk(tri_rises == t0, "R6_glitch", tri_rises - t0, 0);
    chk(ug_en_o, "R7_back_high", int'(ug_en_o), 1);

    // R5/R6: long window stay
    push(4'b0000, "R5");
    push(4'b0010, "R6");
    t0 = cyc;
    set_pwm(0, 0);
    wait_cyc(20);
    chk(tri_off_o && !ug_en_o, "R6_tri", int'({tri_off_o, ug_en_o}), 2);
    chk(t_tri_rise - t0 == SYNC_STAGES + HOLD_CYC + 2, "R6_latency",
        t_tri_rise - t0, SYNC_STAGES + HOLD_CYC + 2);

    // R7: leave window to low
    push(4'b0000, "R7");
    push(4'b0100, "R7");
    set_pwm(0, 1);
    wait_cyc(25);
    chk(lg_en_o && !tri_off_o, "R7_exit_low", int'({lg_en_o, tri_off_o}), 2);

    // R9: slow low -> window -> high
    push(4'b0000, "R9");
    push(4'b0010, "R9");
    push(4'b0000, "R9");
    push(4'b1000, "R9");
    set_pwm(0, 0);
    wait_cyc(8);
    set_pwm(1, 0);
    wait_cyc(25);
    chk(ug_en_o, "R9_ug_on", int'(ug_en_o), 1);

    // R4: both comparator bits set is the window
    push(4'b0000, "R4");
    push(4'b0010, "R4");
    set_pwm(1, 1);
    wait_cyc(20);
    chk(tri_off_o && !ug_en_o, "R4_both_bits", int'({tri_off_o, ug_en_o}), 2);
    push(4'b0000, "R4");
    push(4'b1000, "R4");
    set_pwm(1, 0);
    wait_cyc(25);

    // R8: disable while conducting drops the gate at once
    push(4'b0000, "R8");
    en_i = 1'b0;
    #1;
    chk(!ug_en_o, "R8_immediate_en", int'(ug_en_o), 0);
    wait_cyc(10);
    push(4'b1000, "R8");
    en_i = 1'b1;
    wait_cyc(30);
    chk(ug_en_o, "R8_reenable", int'(ug_en_o), 1);
    push(4'b0000, "R8");
    pgood_i = 1'b0;
    #1;
    chk(!ug_en_o, "R8_immediate_pg", int'(ug_en_o), 0);
    wait_cyc(10);
    push(4'b1000, "R8");
    pgood_i = 1'b1;
    wait_cyc(30);
    chk(ug_en_o, "R8_pg_back", int'(ug_en_o), 1);

    chk(overlap_seen == 0, "R3_no_overlap", overlap_seen, 0);
    chk(exp_q.size() == 0, "R3_all_events_seen", exp_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule